// File: doc/BRIEF.md
# Slave-SPI FPGA Configuration Sequencer

This block is the master side of a serial configuration link. On a start command it pulls the target FPGA's active-low reset line low and drives the SPI chip select low at the same time. It holds both for a programmed reset time and then releases reset. It checks that the target's configuration-done input reads low, keeps chip select low through a long housekeeping wait, and releases chip select briefly.

It then lowers chip select again and streams the image bytes it receives on a valid/ready interface, MSB first, in SPI mode 0. After the last byte it requires the done input to be high. If so, it clocks out whole zero bytes until at least the configured number of activation clocks has been sent, and then raises chip select.

All delays are cycle counts derived at elaboration from the system clock frequency. The done input passes through a two-flop synchronizer before any decision uses it. Elaboration stops with an error if the SCLK frequency is outside 1 MHz to 25 MHz or if a clock phase of 1 is requested. The status outputs are a busy flag, a done flag and a 2-bit error code, plus an indication of whether the target is operating.

Top module: `fpga_cfg_seq`

## Requirements
- R1: A start without the partial flag holds reset_n_o low and cs_n_o low together for ceil(CLK_HZ*RESET_NS/1e9) system cycles, up to two cycles longer. The default is 1 µs.
- R2: If the synchronized done input is high after reset is released, the sequencer sets err_o to 2 (reset failed), drops busy_o, returns cs_n_o high and sends no SCLK pulses.
- R3: After a good reset check, cs_n_o stays low continuously for at least the reset time plus the housekeeping time (default 1200 µs). It then goes high for at least one cycle while busy before any image bit is clocked.
- R4: SCLK idles low. Each byte is sent MSB first. mosi_o never changes while sclk_o stays high, so the target samples it on the rising edge (mode 0).
- R5: cs_n_o is low without a break from the first image bit to the last padding bit, and it is high once the sequence ends.
- R6: If the synchronized done input is low after the last image byte, err_o becomes 3 (done not asserted). In that case no padding clocks are sent, done_o stays low and cs_n_o returns high.
- R7: When done is high after the image, exactly ceil(PAD_BITS/8)*8 zero-valued SCLK pulses follow the image (56 by default), and done_o then rises with err_o equal to 0.
- R8: A start with partial_i set is rejected in the next cycle with err_o equal to 1 (unsupported). busy_o stays low, and reset_n_o, cs_n_o and sclk_o do not toggle.
- R9: operating_o follows the done input after two system clock edges.
- R10: busy_o is high from the cycle after an accepted start until the sequence ends in done or in an error.
- R11: Each SCLK high phase lasts ceil(CLK_HZ/(2*SCLK_HZ)) system cycles, and so does each low phase within a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled while idle |
| partial_i | input | 1 | Partial-reconfiguration request flag qualifying start_i |
| img_data_i | input | 8 | Image byte |
| img_valid_i | input | 1 | Image byte valid |
| img_last_i | input | 1 | Marks the final image byte |
| img_ready_o | output | 1 | Sequencer accepts an image byte |
| cdone_i | input | 1 | Target configuration-done line, asynchronous |
| reset_n_o | output | 1 | Target reset, active low |
| cs_n_o | output | 1 | SPI chip select, active low |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | SPI data to target |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last sequence completed successfully |
| err_o | output | 2 | 0 none, 1 unsupported, 2 reset failed, 3 done not asserted |
| operating_o | output | 1 | Target reports configured (synchronized done) |

## Verification
The hardest situations to reach are the two failure exits, because each needs the done line at the wrong level at one particular moment. The bench drives the done input high before a start to take the reset-failed branch. It also leaves the line low after streaming the image so that the padding phase is skipped. A sweep over image lengths and byte patterns rebuilds the expected serial bit sequence, including the 56 padding zeros, and compares it bit by bit with what was captured on the SCLK rising edges. Pin activity is counted to show that a partial request leaves every pin untouched.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RST,
        S_CHK_RST,
        S_HOUSE,
        S_GAP,
        S_STREAM,
        S_CHK_IMG,
        S_PAD,
        S_FIN
    } seq_state_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_UNSUP   = 2'd1,
        ERR_RSTFAIL = 2'd2,
        ERR_NODONE  = 2'd3
    } seq_err_e;

    // cycles allowed for the two-flop synchronizer to settle before a check
    localparam int SETTLE_CYC = 3;

    function automatic int div_ceil(longint num, longint den);
        return int'((num + den - 64'd1) / den);
    endfunction

    function automatic int ns_to_cyc(longint hz, longint ns);
        int c;
        c = div_ceil(hz * ns, 64'd1_000_000_000);
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/cfg_sync2.sv
module cfg_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/cfg_delay_timer.sv
module cfg_delay_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [TW-1:0] val_i,
    output logic          zero_o
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/cfg_spi_tx.sv
module cfg_spi_tx #(
    parameter int HALF_CYC = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go_i,
    input  logic [7:0] byte_i,
    output logic       idle_o,
    output logic       sclk_o,
    output logic       mosi_o
);
    localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [7:0]    sh_q;
    logic [2:0]    bit_q;
    logic [HW-1:0] hcnt_q;
    logic          sclk_q;
    logic          active_q;
    logic          half_end;

    assign half_end = (hcnt_q == HW'(HALF_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q     <= '0;
            bit_q    <= '0;
            hcnt_q   <= '0;
            sclk_q   <= 1'b0;
            active_q <= 1'b0;
        end else if (!active_q) begin
            if (go_i) begin
                sh_q     <= byte_i;
                bit_q    <= '0;
                hcnt_q   <= '0;
                sclk_q   <= 1'b0;
                active_q <= 1'b1;
            end
        end else if (half_end) begin
            hcnt_q <= '0;
            if (!sclk_q) begin
                sclk_q <= 1'b1;
            end else begin
                sclk_q <= 1'b0;
                if (bit_q == 3'd7) begin
                    active_q <= 1'b0;
                end else begin
                    sh_q  <= {sh_q[6:0], 1'b0};
                    bit_q <= bit_q + 1'b1;
                end
            end
        end else begin
            hcnt_q <= hcnt_q + 1'b1;
        end
    end

    assign idle_o = !active_q;
    assign sclk_o = sclk_q;
    assign mosi_o = active_q & sh_q[7];

    // R4: data held steady across every high phase of SCLK
    a_r4_mosi_steady: assert property (@(posedge clk) disable iff (rst)
        (sclk_q && $past(sclk_q)) |-> $stable(mosi_o));

    // R4: clock rests low whenever no byte is in flight
    a_r4_sclk_rest_low: assert property (@(posedge clk) disable iff (rst)
        !active_q |-> !sclk_q);
endmodule

// File: rtl/fpga_cfg_seq.sv
module fpga_cfg_seq
    import cfg_seq_pkg::*;
#(
    parameter int CLK_HZ       = 100_000_000,
    parameter int SCLK_HZ      = 10_000_000,
    parameter int RESET_NS     = 1_000,
    parameter int HOUSEKEEP_NS = 1_200_000,
    parameter int PAD_BITS     = 49,
    parameter int CPHA         = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       partial_i,
    input  logic [7:0] img_data_i,
    input  logic       img_valid_i,
    input  logic       img_last_i,
    output logic       img_ready_o,
    input  logic       cdone_i,
    output logic       reset_n_o,
    output logic       cs_n_o,
    output logic       sclk_o,
    output logic       mosi_o,
    output logic       busy_o,
    output logic       done_o,
    output logic [1:0] err_o,
    output logic       operating_o
);
    localparam int RST_CYC   = ns_to_cyc(longint'(CLK_HZ), longint'(RESET_NS));
    localparam int HK_CYC    = ns_to_cyc(longint'(CLK_HZ), longint'(HOUSEKEEP_NS));
    localparam int HALF_CYC  = div_ceil(longint'(CLK_HZ), 2 * longint'(SCLK_HZ));
    localparam int GAP_CYC   = 2 * HALF_CYC;
    localparam int PAD_BYTES = div_ceil(longint'(PAD_BITS), 64'd8);
    localparam int TW        = $clog2(RST_CYC + HK_CYC + GAP_CYC + SETTLE_CYC + 2);
    localparam int PCW       = $clog2(PAD_BYTES + 1);

    if (SCLK_HZ < 1_000_000 || SCLK_HZ > 25_000_000 || CPHA != 0) begin : g_bad_cfg
        $error("fpga_cfg_seq: SCLK must be 1..25 MHz with clock phase 0");
    end

    seq_state_e      state_q, state_d;
    seq_err_e        err_q;
    logic            busy_q, done_q, last_seen_q;
    logic [PCW-1:0]  pad_left_q;
    logic            tmr_load, tmr_zero;
    logic [TW-1:0]   tmr_val;
    logic            tx_go, tx_idle;
    logic [7:0]      tx_byte;
    logic            cdone_s;
    logic            accept;

    cfg_sync2 u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (cdone_i),
        .q_o (cdone_s)
    );

    cfg_delay_timer #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    cfg_spi_tx #(.HALF_CYC(HALF_CYC)) u_tx (
        .clk    (clk),
        .rst    (rst),
        .go_i   (tx_go),
        .byte_i (tx_byte),
        .idle_o (tx_idle),
        .sclk_o (sclk_o),
        .mosi_o (mosi_o)
    );

    assign img_ready_o = (state_q == S_STREAM) && tx_idle && !last_seen_q;
    assign accept      = img_ready_o && img_valid_i;
    assign tx_go       = accept || ((state_q == S_PAD) && tx_idle && (pad_left_q != '0));
    assign tx_byte     = (state_q == S_PAD) ? 8'h00 : img_data_i;

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            S_IDLE: if (start_i && !partial_i) begin
                state_d  = S_RST;
                tmr_load = 1'b1;
                tmr_val  = TW'(RST_CYC - 1);
            end
            S_RST: if (tmr_zero) begin
                state_d  = S_CHK_RST;
                tmr_load = 1'b1;
                tmr_val  = TW'(SETTLE_CYC - 1);
            end
            S_CHK_RST: if (tmr_zero) begin
                state_d  = cdone_s ? S_IDLE : S_HOUSE;
                tmr_load = 1'b1;
                tmr_val  = TW'(HK_CYC - 1);
            end
            S_HOUSE: if (tmr_zero) begin
                state_d  = S_GAP;
                tmr_load = 1'b1;
                tmr_val  = TW'(GAP_CYC - 1);
            end
            S_GAP: if (tmr_zero) state_d = S_STREAM;
            S_STREAM: if (last_seen_q && tx_idle) begin
                state_d  = S_CHK_IMG;
                tmr_load = 1'b1;
                tmr_val  = TW'(SETTLE_CYC - 1);
            end
            S_CHK_IMG: if (tmr_zero) state_d = cdone_s ? S_PAD : S_IDLE;
            S_PAD: if (tx_idle && pad_left_q == '0) state_d = S_FIN;
            S_FIN: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= S_IDLE;
            err_q       <= ERR_NONE;
            busy_q      <= 1'b0;
            done_q      <= 1'b0;
            last_seen_q <= 1'b0;
            pad_left_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && start_i) begin
                done_q <= 1'b0;
                if (partial_i) begin
                    err_q <= ERR_UNSUP;
                end else begin
                    err_q  <= ERR_NONE;
                    busy_q <= 1'b1;
                end
            end
            if (state_q == S_CHK_RST && tmr_zero && cdone_s) begin
                err_q  <= ERR_RSTFAIL;
                busy_q <= 1'b0;
            end
            if (state_q == S_CHK_IMG && tmr_zero) begin
                if (cdone_s) begin
                    pad_left_q <= PCW'(PAD_BYTES);
                end else begin
                    err_q  <= ERR_NODONE;
                    busy_q <= 1'b0;
                end
            end
            if (state_q == S_PAD && tx_go) pad_left_q <= pad_left_q - 1'b1;
            if (state_q == S_FIN) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end
            if (state_q == S_GAP) last_seen_q <= 1'b0;
            else if (accept && img_last_i) last_seen_q <= 1'b1;
        end
    end

    assign reset_n_o   = (state_q != S_RST);
    assign cs_n_o      = !(state_q inside {S_RST, S_CHK_RST, S_HOUSE, S_STREAM, S_CHK_IMG, S_PAD});
    assign busy_o      = busy_q;
    assign done_o      = done_q;
    assign err_o       = err_q;
    assign operating_o = cdone_s;

    // R1: reset is only applied with chip select low
    a_r1_reset_with_cs: assert property (@(posedge clk) disable iff (rst)
        !reset_n_o |-> !cs_n_o);

    // R8: a partial request leaves all pins idle and flags unsupported
    a_r8_partial_reject: assert property (@(posedge clk) disable iff (rst)
        (start_i && partial_i && state_q == S_IDLE) |=>
            (err_o == ERR_UNSUP && !busy_o && cs_n_o && reset_n_o));

    // R2: done seen high after reset ends the run with chip select released
    a_r2_reset_fail: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_CHK_RST && tmr_zero && cdone_s) |=>
            (err_o == ERR_RSTFAIL && cs_n_o && !busy_o));

    // R5: image bytes are only taken while chip select is low
    a_r5_ready_in_frame: assert property (@(posedge clk) disable iff (rst)
        img_ready_o |-> !cs_n_o);

    // R7: a successful finish carries no error and releases chip select
    a_r7_done_clean: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (err_o == ERR_NONE && cs_n_o && !busy_o));

    // R10: busy is never left high while the sequencer sits idle
    a_r10_busy_idle: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_IDLE && !start_i) |=> (state_q != S_IDLE || !busy_o));
endmodule

// File: tb/fpga_cfg_seq_test.sv
module fpga_cfg_seq_test;
    localparam int CLK_HZ  = 100_000_000;
    localparam int SCLK_HZ = 25_000_000;
    localparam int RST_C   = 100;
    localparam int HK_C    = 200;
    localparam int HALF    = 2;
    localparam int PAD_CLK = 56;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0, partial_i = 1'b0;
    logic [7:0] img_data_i = '0;
    logic       img_valid_i = 1'b0, img_last_i = 1'b0;
    logic       img_ready_o;
    logic       cdone_i = 1'b0;
    logic       reset_n_o, cs_n_o, sclk_o, mosi_o, busy_o, done_o, operating_o;
    logic [1:0] err_o;

    fpga_cfg_seq #(
        .CLK_HZ(CLK_HZ), .SCLK_HZ(SCLK_HZ), .RESET_NS(1000),
        .HOUSEKEEP_NS(2000), .PAD_BITS(49), .CPHA(0)
    ) uut (
        .clk(clk), .rst(rst), .start_i(start_i), .partial_i(partial_i),
        .img_data_i(img_data_i), .img_valid_i(img_valid_i), .img_last_i(img_last_i),
        .img_ready_o(img_ready_o), .cdone_i(cdone_i), .reset_n_o(reset_n_o),
        .cs_n_o(cs_n_o), .sclk_o(sclk_o), .mosi_o(mosi_o), .busy_o(busy_o),
        .done_o(done_o), .err_o(err_o), .operating_o(operating_o)
    );

    always #5 clk = ~clk;

    int checks = 0, fails = 0;
    bit finished = 0;

    // monitors
    int rst_low, nseg, cur_seg, gap_hi, tog, mosi_bad, hi_bad, hi_run, nbits;
    int seg[4];
    logic cap[1024];
    logic p_cr = 1'b1, p_cs = 1'b1, p_sc = 1'b0, p_mo = 1'b0;
    logic [7:0] img[16];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        rst_low = 0; nseg = 0; cur_seg = 0; gap_hi = 0; tog = 0;
        mosi_bad = 0; hi_bad = 0; hi_run = 0; nbits = 0;
        for (int i = 0; i < 4; i++) seg[i] = 0;
    endtask

    always @(negedge clk) begin
        if (!reset_n_o) rst_low++;
        if (!cs_n_o) cur_seg++;
        else if (cur_seg != 0) begin
            if (nseg < 4) seg[nseg] = cur_seg;
            nseg++;
            cur_seg = 0;
        end
        if (cs_n_o && busy_o) gap_hi++;
        if (reset_n_o != p_cr) tog++;
        if (cs_n_o != p_cs) tog++;
        if (sclk_o != p_sc) tog++;
        if (sclk_o && p_sc && mosi_o != p_mo) mosi_bad++;
        if (sclk_o) hi_run++;
        else if (p_sc) begin
            if (hi_run != HALF) hi_bad++;
            hi_run = 0;
        end
        p_cr = reset_n_o; p_cs = cs_n_o; p_sc = sclk_o; p_mo = mosi_o;
    end

    always @(posedge sclk_o) begin
        if (!cs_n_o) begin
            if (nbits < 1024) cap[nbits] = mosi_o;
            nbits++;
        end
    end

    task automatic wait_idle();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (!busy_o) break;
        end
    endtask

    task automatic pulse_start(input logic part);
        @(negedge clk);
        start_i = 1'b1; partial_i = part;
        @(negedge clk);
        start_i = 1'b0; partial_i = 1'b0;
    endtask

    task automatic run_img(input int n, input int pat, input logic cd_after);
        int bad_bits;
        int exp_n;
        logic e;
        for (int i = 0; i < n; i++) begin
            case (pat)
                0: img[i] = 8'((i * 37 + n * 11) ^ 8'hA5);
                1: img[i] = 8'h00;
                2: img[i] = 8'hFF;
                default: img[i] = (i % 2 == 0) ? 8'h80 : 8'h01;
            endcase
        end
        cdone_i = 1'b0;
        repeat (3) @(negedge clk);
        clear_mon();
        pulse_start(1'b0);
        chk(busy_o == 1'b1, "R10", "busy after start", int'(busy_o), 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            img_valid_i = 1'b1; img_data_i = img[i]; img_last_i = (i == n - 1);
            for (int t = 0; t < 20000 && !img_ready_o; t++) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        img_valid_i = 1'b0; img_last_i = 1'b0;
        cdone_i = cd_after;
        wait_idle();
        repeat (3) @(negedge clk);
        exp_n = cd_after ? 8 * n + PAD_CLK : 8 * n;
        bad_bits = 0;
        for (int k = 0; k < exp_n && k < 1024; k++) begin
            e = (k < 8 * n) ? img[k / 8][7 - (k % 8)] : 1'b0;
            if (cap[k] !== e) bad_bits++;
        end
        chk(rst_low >= RST_C && rst_low <= RST_C + 2, "R1", "reset low cycles", rst_low, RST_C);
        chk(seg[0] >= RST_C + HK_C, "R3", "first cs low span", seg[0], RST_C + HK_C);
        chk(gap_hi >= 2, "R3", "cs high gap before image", gap_hi, 2);
        chk(nbits == exp_n, cd_after ? "R7" : "R6", "sclk pulses in frame", nbits, exp_n);
        chk(bad_bits == 0, cd_after ? "R7" : "R4", "mismatched serial bits", bad_bits, 0);
        chk(mosi_bad == 0, "R4", "mosi moves while sclk high", mosi_bad, 0);
        chk(hi_bad == 0, "R11", "sclk high phase length", hi_bad, 0);
        chk(nseg == 2 && cs_n_o, "R5", "cs low segments", nseg, 2);
        if (cd_after) begin
            chk(done_o == 1'b1 && err_o == 2'd0, "R7", "done flag", int'(done_o), 1);
        end else begin
            chk(err_o == 2'd3 && !done_o, "R6", "error code", int'(err_o), 3);
        end
        chk(!busy_o, "R10", "busy after end", int'(busy_o), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        clear_mon();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk(reset_n_o && cs_n_o && !sclk_o, "R5", "pins after reset", int'(cs_n_o), 1);
        chk(!busy_o && !done_o && err_o == 2'd0 && !img_ready_o, "R10", "status after reset",
            int'(busy_o), 0);

        // R8: partial request rejected, no pin activity
        clear_mon();
        pulse_start(1'b1);
        chk(err_o == 2'd1 && !busy_o, "R8", "partial error code", int'(err_o), 1);
        repeat (20) @(negedge clk);
        chk(tog == 0 && cs_n_o && reset_n_o, "R8", "pin toggles on partial", tog, 0);
        chk(!busy_o, "R8", "busy on partial", int'(busy_o), 0);

        // R9: operating follows done line after two edges
        cdone_i = 1'b1;
        @(negedge clk);
        chk(operating_o == 1'b0, "R9", "operating after one edge", int'(operating_o), 0);
        @(negedge clk);
        chk(operating_o == 1'b1, "R9", "operating after two edges", int'(operating_o), 1);

        // R2: done high during reset check
        clear_mon();
        pulse_start(1'b0);
        wait_idle();
        repeat (2) @(negedge clk);
        chk(err_o == 2'd2, "R2", "reset-fail code", int'(err_o), 2);
        chk(cs_n_o && reset_n_o && !done_o, "R2", "cs released", int'(cs_n_o), 1);
        chk(nbits == 0, "R2", "sclk pulses", nbits, 0);
        chk(rst_low >= RST_C && rst_low <= RST_C + 2, "R1", "reset low cycles", rst_low, RST_C);

        // sweeps of successful loads
        for (int n = 1; n <= 6; n++) run_img(n, 0, 1'b1);
        for (int p = 1; p <= 3; p++) run_img(3, p, 1'b1);
        // done missing after image
        run_img(2, 0, 1'b0);
        run_img(4, 3, 1'b0);
        // recovery: a good run after an error
        run_img(1, 2, 1'b1);
        chk(operating_o == 1'b1, "R9", "operating after load", int'(operating_o), 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule